// File: doc/BRIEF.md
# Count-Min Sketch Update Engine

This block holds a grid of saturating counters, laid out as a number of rows of equal width, and uses it for approximate frequency counting over a stream of keyed items. Each item carries a key and an increment. The engine hashes the key once per row, each row with its own hash function, and adds the increment to the addressed counter in every row. Many items that share a key always land on the same set of counters, one per row.

A point query hashes its key the same way and returns the smallest of the counters it addresses. That value is an upper bound on the true total for the key. Items and queries share one in-order pipeline, so a query always reflects every item accepted before it. A clear strobe empties the whole grid by sweeping one column per cycle. Reset runs the same sweep.

Top module: `cms_engine`

## Requirements
- R1: An accepted item (item_valid and item_ready high at a rising edge) adds item_inc to one counter in every row, namely the counter at the column that the row's hash selects for item_key.
- R2: Row j selects column ((A_j*key + B_j) mod P) mod COLS, where P = 2^31-1, A_j = ((j*0x2545F491 + 0x1B873593) mod (P-1)) + 1 (never zero), B_j = (j*0x68E31DA4 + 0x0B4F1C37) mod P, and the key is zero-extended to 32 bits.
- R3: A query accepted at a rising edge produces result_min equal to the smallest of the counters its key addresses, one per row.
- R4: A counter whose sum would exceed 2^CW-1 holds the all-ones value instead of wrapping.
- R5: Items accepted on consecutive cycles, including repeats of the same key, all accumulate, and none of their updates is lost.
- R6: A query reflects every item accepted before it, including an item accepted on the cycle just before the query.
- R7: A clear_req pulse while the engine is running drops item_ready and query_ready from the next cycle. Items accepted before or on the cycle of the pulse are applied first. Every counter then reads zero, ready stays low for at least COLS cycles, and normal updates resume afterwards.
- R8: result_valid rises for exactly one cycle, three rising edges after the edge that accepts the query. While query_valid is high, item_ready is low, so a query takes priority over an item offered on the same cycle.
- R9: query_ready falls only on the cycle after a clear_req pulse.
- R10: During reset, both ready outputs and result_valid are low. After reset is released, ready stays low for at least COLS cycles, and then every counter reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| item_valid | input | 1 | Item offered |
| item_ready | output | 1 | Item can be accepted this cycle |
| item_key | input | KW | Item key |
| item_inc | input | CW | Amount added to each addressed counter |
| query_valid | input | 1 | Point query offered |
| query_ready | output | 1 | Query can be accepted this cycle |
| query_key | input | KW | Key to look up |
| clear_req | input | 1 | Pulse that starts a full clear |
| result_valid | output | 1 | result_min is valid this cycle |
| result_min | output | CW | Minimum of the addressed counters |

## Verification
The bench builds the engine with 3 rows of 16 columns, 8-bit counters and 16-bit keys. With so few columns, distinct keys collide often, so the minimum logic, the sharing of counters between keys and the saturation limit are all reached within a few hundred items. The bench keeps its own copy of the grid, fills it with the modular hash computed arithmetically, and sweeps queries over hundreds of keys. It also drives back-to-back repeats of one key to exercise the forwarding path, and places an item on the same cycle as a clear strobe.

// File: rtl/cms_pkg.sv
package cms_pkg;

    localparam logic [31:0] MERSENNE = 32'h7FFF_FFFF;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_ADD  = 2'd1,
        OP_QRY  = 2'd2
    } op_e;

    typedef enum logic [1:0] {
        CS_SWEEP = 2'd0,
        CS_DRAIN = 2'd1,
        CS_RUN   = 2'd2
    } clr_state_e;

    // Multiplier for a row: always in 1 .. 2^31-2.
    function automatic logic [30:0] coef_mul(int unsigned row);
        logic [63:0] t;
        t = (64'(row) * 64'h2545_F491 + 64'h1B87_3593) % 64'h7FFF_FFFE;
        return 31'(t + 64'd1);
    endfunction

    // Offset for a row: in 0 .. 2^31-2.
    function automatic logic [30:0] coef_off(int unsigned row);
        logic [63:0] t;
        t = (64'(row) * 64'h68E3_1DA4 + 64'h0B4F_1C37) % 64'h7FFF_FFFF;
        return 31'(t);
    endfunction

    // (a*key + b) mod (2^31-1), reduced by folding the high part twice.
    function automatic logic [30:0] mix_key(logic [30:0] a, logic [30:0] b,
                                            logic [31:0] key);
        logic [63:0] x;
        logic [33:0] f1;
        logic [31:0] f2;
        x  = 64'(a) * 64'(key) + 64'(b);
        f1 = 34'(x[30:0]) + 34'(x[63:31]);
        f2 = 32'(f1[30:0]) + 32'(f1[33:31]);
        if (f2 >= MERSENNE) f2 = f2 - MERSENNE;
        return f2[30:0];
    endfunction

endpackage

// File: rtl/cms_hash.sv
module cms_hash #(
    parameter int ROW  = 0,
    parameter int COLS = 256,
    parameter int IW   = 8
) (
    input  logic [31:0]   key,
    output logic [IW-1:0] col
);
    import cms_pkg::*;

    localparam logic [30:0] MUL = coef_mul(ROW);
    localparam logic [30:0] OFF = coef_off(ROW);

    logic [30:0] h;

    assign h   = mix_key(MUL, OFF, key);
    assign col = IW'(h % 31'(COLS));
endmodule

// File: rtl/cms_row.sv
module cms_row #(
    parameter int COLS = 256,
    parameter int CW   = 32,
    parameter int IW   = 8
) (
    input  logic          clk,
    input  logic [IW-1:0] rd_idx,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [CW-1:0] wr_data,
    input  logic          clr_en,
    input  logic [IW-1:0] clr_idx,
    output logic [CW-1:0] rd_data
);
    logic [CW-1:0] cells [COLS];

    always_ff @(posedge clk) begin
        if (clr_en) begin
            cells[clr_idx] <= '0;
        end else if (wr_en) begin
            cells[wr_idx] <= wr_data;
        end
    end

    // A write still pending at the next edge is bypassed to the reader.
    always_comb begin
        if (wr_en && (wr_idx == rd_idx)) rd_data = wr_data;
        else                             rd_data = cells[rd_idx];
    end
endmodule

// File: rtl/cms_clear_ctrl.sv
module cms_clear_ctrl #(
    parameter int COLS = 256,
    parameter int IW   = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear_req,
    input  logic          pipe_empty,
    output logic          running,
    output logic          sweep_en,
    output logic [IW-1:0] sweep_col
);
    import cms_pkg::*;

    localparam logic [IW-1:0] LAST_COL = IW'(COLS - 1);

    clr_state_e    state;
    logic [IW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= CS_SWEEP;
            cnt   <= '0;
        end else begin
            case (state)
                CS_RUN: begin
                    if (clear_req) state <= CS_DRAIN;
                end
                CS_DRAIN: begin
                    if (pipe_empty) begin
                        state <= CS_SWEEP;
                        cnt   <= '0;
                    end
                end
                CS_SWEEP: begin
                    if (cnt == LAST_COL) state <= CS_RUN;
                    else                 cnt   <= cnt + 1'b1;
                end
                default: state <= CS_RUN;
            endcase
        end
    end

    assign running   = (state == CS_RUN);
    assign sweep_en  = (state == CS_SWEEP);
    assign sweep_col = cnt;
endmodule

// File: rtl/cms_engine.sv
module cms_engine #(
    parameter int ROWS = 8,
    parameter int COLS = 256,
    parameter int CW   = 32,
    parameter int KW   = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          item_valid,
    output logic          item_ready,
    input  logic [KW-1:0] item_key,
    input  logic [CW-1:0] item_inc,
    input  logic          query_valid,
    output logic          query_ready,
    input  logic [KW-1:0] query_key,
    input  logic          clear_req,
    output logic          result_valid,
    output logic [CW-1:0] result_min
);
    import cms_pkg::*;

    localparam int IW = (COLS > 1) ? $clog2(COLS) : 1;

    // Control
    logic          running, sweep_en, pipe_empty;
    logic [IW-1:0] sweep_col;

    // Stage 0: acceptance and hashing
    logic          take_item, take_query;
    logic [KW-1:0] key0;
    op_e           op0;
    logic [IW-1:0] idx0 [ROWS];

    // Stage 1: addresses registered, counters read
    op_e           s1_op;
    logic [CW-1:0] s1_inc;
    logic [IW-1:0] s1_idx [ROWS];
    logic [CW-1:0] rd_data [ROWS];

    // Stage 2: values registered, sum written back or minimum taken
    op_e           s2_op;
    logic [CW-1:0] s2_inc;
    logic [IW-1:0] s2_idx [ROWS];
    logic [CW-1:0] s2_val [ROWS];
    logic [CW-1:0] wdata  [ROWS];
    logic          wr_en;
    logic [CW-1:0] row_min;

    cms_clear_ctrl #(.COLS(COLS), .IW(IW)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .clear_req  (clear_req),
        .pipe_empty (pipe_empty),
        .running    (running),
        .sweep_en   (sweep_en),
        .sweep_col  (sweep_col)
    );

    assign query_ready = running;
    assign item_ready  = running && !query_valid;
    assign take_query  = query_valid && query_ready;
    assign take_item   = item_valid && item_ready;
    assign key0        = take_query ? query_key : item_key;
    assign pipe_empty  = (s1_op == OP_NONE) && (s2_op == OP_NONE);

    always_comb begin
        if (take_query)     op0 = OP_QRY;
        else if (take_item) op0 = OP_ADD;
        else                op0 = OP_NONE;
    end

    assign wr_en = (s2_op == OP_ADD);

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        cms_hash #(.ROW(r), .COLS(COLS), .IW(IW)) u_hash (
            .key (32'(key0)),
            .col (idx0[r])
        );

        cms_row #(.COLS(COLS), .CW(CW), .IW(IW)) u_row (
            .clk     (clk),
            .rd_idx  (s1_idx[r]),
            .wr_en   (wr_en),
            .wr_idx  (s2_idx[r]),
            .wr_data (wdata[r]),
            .clr_en  (sweep_en),
            .clr_idx (sweep_col),
            .rd_data (rd_data[r])
        );
    end

    // Saturating sum per row
    always_comb begin
        logic [CW:0] sum;
        for (int r = 0; r < ROWS; r++) begin
            sum      = {1'b0, s2_val[r]} + {1'b0, s2_inc};
            wdata[r] = sum[CW] ? {CW{1'b1}} : sum[CW-1:0];
        end
    end

    // Minimum across rows
    always_comb begin
        row_min = s2_val[0];
        for (int r = 1; r < ROWS; r++) begin
            if (s2_val[r] < row_min) row_min = s2_val[r];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_op        <= OP_NONE;
            s2_op        <= OP_NONE;
            result_valid <= 1'b0;
        end else begin
            s1_op        <= op0;
            s2_op        <= s1_op;
            result_valid <= (s2_op == OP_QRY);
        end
        s1_inc     <= item_inc;
        s2_inc     <= s1_inc;
        result_min <= row_min;
        for (int r = 0; r < ROWS; r++) begin
            s1_idx[r] <= idx0[r];
            s2_idx[r] <= s1_idx[r];
            s2_val[r] <= rd_data[r];
        end
    end
endmodule

// File: rtl/cms_engine_chk.sv
module cms_engine_chk #(
    parameter int CW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          item_ready,
    input logic          query_valid,
    input logic          query_ready,
    input logic          clear_req,
    input logic          result_valid,
    input logic [CW-1:0] result_min
);
    // R8: result exactly three edges after the accepting edge
    a_r8_result_latency: assert property (@(posedge clk) disable iff (rst)
        result_valid == $past(query_valid && query_ready, 3));

    // R8: a pending query blocks items
    a_r8_query_priority: assert property (@(posedge clk) disable iff (rst)
        query_valid |-> !item_ready);

    // R7: clear pulse drops both readies on the next cycle
    a_r7_clear_drops_ready: assert property (@(posedge clk) disable iff (rst)
        (clear_req && query_ready) |=> (!query_ready && !item_ready));

    // R9: readiness is lost only after a clear request
    a_r9_ready_falls_on_clear: assert property (@(posedge clk) disable iff (rst)
        $fell(query_ready) |-> $past(clear_req));

    // R3: a reported minimum is never unknown
    a_r3_result_known: assert property (@(posedge clk) disable iff (rst)
        result_valid |-> !$isunknown(result_min));
endmodule

bind cms_engine cms_engine_chk #(.CW(CW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .item_ready   (item_ready),
    .query_valid  (query_valid),
    .query_ready  (query_ready),
    .clear_req    (clear_req),
    .result_valid (result_valid),
    .result_min   (result_min)
);

// File: tb/test_cms_engine.sv
module test_cms_engine;
    localparam int ROWS = 3;
    localparam int COLS = 16;
    localparam int CW   = 8;
    localparam int KW   = 16;
    localparam longint unsigned P = 64'h7FFF_FFFF;
    localparam int unsigned TOP = 255;

    logic          clk = 1'b0;
    logic          rst;
    logic          item_valid, item_ready;
    logic [KW-1:0] item_key;
    logic [CW-1:0] item_inc;
    logic          query_valid, query_ready;
    logic [KW-1:0] query_key;
    logic          clear_req;
    logic          result_valid;
    logic [CW-1:0] result_min;

    int errs = 0;
    int checks = 0;
    bit done = 0;
    int unsigned model [ROWS][COLS];

    always #10 clk = ~clk;

    cms_engine #(.ROWS(ROWS), .COLS(COLS), .CW(CW), .KW(KW)) i_cms_engine (
        .clk(clk), .rst(rst),
        .item_valid(item_valid), .item_ready(item_ready),
        .item_key(item_key), .item_inc(item_inc),
        .query_valid(query_valid), .query_ready(query_ready),
        .query_key(query_key), .clear_req(clear_req),
        .result_valid(result_valid), .result_min(result_min)
    );

    task automatic chk(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R2: column choice computed directly with modular arithmetic
    function automatic int unsigned col_of(int r, int unsigned key);
        longint unsigned a, b;
        a = ((longint'(r) * 64'h2545_F491 + 64'h1B87_3593) % (P - 1)) + 1;
        b = (longint'(r) * 64'h68E3_1DA4 + 64'h0B4F_1C37) % P;
        return int'(((a * longint'(key) + b) % P) % COLS);
    endfunction

    function automatic void model_add(int unsigned key, int unsigned inc);
        for (int r = 0; r < ROWS; r++) begin
            int unsigned c, s;
            c = col_of(r, key);
            s = model[r][c] + inc;
            model[r][c] = (s > TOP) ? TOP : s;
        end
    endfunction

    function automatic int unsigned model_min(int unsigned key);
        int unsigned m;
        m = model[0][col_of(0, key)];
        for (int r = 1; r < ROWS; r++)
            if (model[r][col_of(r, key)] < m) m = model[r][col_of(r, key)];
        return m;
    endfunction

    function automatic void model_clear();
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) model[r][c] = 0;
    endfunction

    // Called at a falling edge; returns at the falling edge after acceptance
    task automatic put_item(int unsigned key, int unsigned inc);
        query_valid = 1'b0;
        item_valid  = 1'b1;
        item_key    = KW'(key);
        item_inc    = CW'(inc);
        while (!item_ready) @(negedge clk);
        @(posedge clk);
        model_add(key, inc);
        @(negedge clk);
    endtask

    task automatic ask(int unsigned key, string req);
        int unsigned exp;
        item_valid  = 1'b0;
        query_valid = 1'b1;
        query_key   = KW'(key);
        while (!query_ready) @(negedge clk);
        exp = model_min(key);
        @(posedge clk);
        @(negedge clk);
        query_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(result_valid == 1'b1, "R8 result timing", longint'(result_valid), 1);
        chk(result_min == CW'(exp), req, longint'(result_min), longint'(exp));
    endtask

    task automatic wait_ready(string req);
        int n = 0;
        while (!query_ready && n < 1000) begin
            @(negedge clk);
            n++;
        end
        chk(n >= COLS, req, n, COLS);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        item_valid = 1'b0; item_key = '0; item_inc = '0;
        query_valid = 1'b0; query_key = '0; clear_req = 1'b0;
        model_clear();
        repeat (4) @(negedge clk);
        chk(item_ready == 1'b0, "R10 item_ready in reset", longint'(item_ready), 0);
        chk(query_ready == 1'b0, "R10 query_ready in reset", longint'(query_ready), 0);
        chk(result_valid == 1'b0, "R10 result_valid in reset", longint'(result_valid), 0);
        rst = 1'b0;
        wait_ready("R10 sweep length after reset");
        for (int k = 0; k < 40; k++) ask(k * 7, "R10 zero after reset");

        // R1/R2: single items, addressed by the modular hash
        put_item(5, 10);
        ask(5, "R1 single item");
        put_item(1000, 3);
        put_item(777, 1);
        ask(1000, "R1 second key");
        ask(777, "R2 third key");
        ask(12345, "R3 untouched key minimum");

        // R8: query takes priority over an item on the same cycle
        item_valid  = 1'b1;
        query_valid = 1'b1;
        #1;
        chk(item_ready == 1'b0, "R8 item blocked by query", longint'(item_ready), 0);
        item_valid  = 1'b0;
        query_valid = 1'b0;
        @(negedge clk);

        // R5: back-to-back repeats of one key, then alternating keys
        for (int i = 0; i < 12; i++) put_item(42, 2);
        ask(42, "R5 repeated key");
        for (int i = 0; i < 6; i++) begin
            put_item(300, 1);
            put_item(301, 3);
        end
        ask(300, "R5 alternating key a");
        ask(301, "R5 alternating key b");

        // R6: query directly behind its item
        put_item(900, 4);
        ask(900, "R6 query after item");
        put_item(900, 7);
        put_item(900, 7);
        ask(900, "R6 query after two items");

        // R4: saturation
        put_item(60000, 200);
        put_item(60000, 100);
        ask(60000, "R4 saturate at all-ones");
        put_item(61111, 255);
        put_item(61111, 1);
        ask(61111, "R4 saturate from full step");

        // R3: sweep of many keys against the model
        for (int k = 0; k < 200; k++) put_item(k, (k % 4) + 1);
        for (int k = 0; k < 200; k++) ask(k, "R3 sweep minimum");

        // R7: clear with an item on the same cycle
        item_valid = 1'b1;
        item_key   = KW'(11);
        item_inc   = CW'(9);
        clear_req  = 1'b1;
        chk(item_ready == 1'b1, "R7 ready before clear", longint'(item_ready), 1);
        @(posedge clk);
        @(negedge clk);
        clear_req  = 1'b0;
        item_valid = 1'b0;
        chk(item_ready == 1'b0, "R7 item_ready low after clear", longint'(item_ready), 0);
        chk(query_ready == 1'b0, "R9 query_ready low after clear", longint'(query_ready), 0);
        wait_ready("R7 clear length");
        model_clear();
        for (int k = 0; k < 32; k++) ask(k, "R7 zero after clear");
        ask(60000, "R7 saturated counter cleared");
        put_item(11, 5);
        ask(11, "R7 update after clear");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule